// File: doc/BRIEF.md
# SPI EEPROM Page Program Sequencer

This block writes a run of bytes into a page-organised serial EEPROM over a four-wire SPI link. A host pulses `start` with a byte address, a byte count and an erase flag, then supplies the bytes on a valid/ready stream. The sequencer breaks the run into program transactions that never cross a 64-byte page. Before each one it issues a write-enable frame, and it polls the device status register until the internal write cycle ends.

The first action of every job is a status poll, so a write still running from earlier work is waited out before any new command is sent. Each poll is a separate chip-select frame. The poll count restarts at zero for every poll session, and a session that sees the busy flag set `POLL_LIMIT` times in a row ends the job with an error pulse. In erase mode the input stream is not used, and every data byte sent is 0xFF.

Top module: `spi_page_writer`

## Requirements
- R1: After `start` is accepted, the first frame is a status read. Every status read is its own frame made of opcode 0x05 followed by one dummy byte. The write-in-progress flag is bit 0 of the second byte received, and no other status bit affects the sequence.
- R2: Each page is written with two frames. The first holds only opcode 0x06. The second sends opcode 0x02, then address bits 15:8, then address bits 7:0, then the data bytes in ascending address order.
- R3: A program frame ends after the byte whose following address has its low 6 bits at zero, or after the last byte of the job. No program frame covers bytes from two 64-byte pages.
- R4: After every program frame, status reads repeat until bit 0 reads clear. This happens before the next write-enable and before completion.
- R5: If `POLL_LIMIT` consecutive status reads in one session report busy, the block sends no further frames. It pulses `error` for one cycle and returns to idle without pulsing `done`.
- R6: Bytes go out MSB first. `spi_mosi` changes only while `spi_sck` is low, `spi_miso` is sampled while `spi_sck` is high, and `spi_sck` is low whenever `spi_cs_n` is high.
- R7: Between any two frames, `spi_cs_n` stays high for at least `CS_GAP` clock cycles.
- R8: In erase mode every data byte is 0xFF and `din_ready` is never asserted.
- R9: A data byte is taken only on a cycle where `din_valid` and `din_ready` are both high. A write job takes exactly `length` bytes.
- R10: On success `done` is high for exactly one cycle, in the cycle where `busy` falls. A job with `length` of zero performs only the initial status poll and then completes.
- R11: `start` has no effect while `busy` is high.
- R12: After reset `spi_cs_n` is 1, and `spi_sck`, `busy`, `done`, `error` and `din_ready` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a job (taken only when idle) |
| erase | input | 1 | Write 0xFF instead of stream data |
| start_addr | input | ADDR_W | First byte address |
| length | input | LEN_W | Number of bytes |
| din | input | 8 | Data byte stream |
| din_valid | input | 1 | Stream byte valid |
| din_ready | output | 1 | Sequencer takes a byte this cycle if valid |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle pulse on successful completion |
| error | output | 1 | One-cycle pulse on poll timeout |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the device |
| spi_miso | input | 1 | Serial data from the device |

## Verification
The assertions assume the host asserts `start` only with a start address small enough that address plus length fits in 16 bits. They also assume `spi_miso` changes only while `spi_sck` is low. The bench device model updates `spi_miso` only after it sees the serial clock fall, and it keeps every job inside a 512-byte window. The stream driver changes `din` and `din_valid` only on falling clock edges, and with gaps in some runs. Busy responses are bounded by a count in the model, except in the one run meant to exhaust the poll limit.

// File: rtl/spw_pkg.sv
package spw_pkg;

    localparam logic [7:0] OP_WREN    = 8'h06;
    localparam logic [7:0] OP_PROG    = 8'h02;
    localparam logic [7:0] OP_RDSR    = 8'h05;
    localparam logic [7:0] FILL_BYTE  = 8'hFF;
    localparam logic [7:0] DUMMY_BYTE = 8'h00;
    localparam int         WIP_BIT    = 0;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_GAP,
        SEQ_XFER,
        SEQ_FEED
    } seq_state_e;

    typedef enum logic [2:0] {
        PH_RDSR,
        PH_DUMMY,
        PH_WREN,
        PH_PROG,
        PH_AHI,
        PH_ALO,
        PH_DATA
    } phase_e;

    typedef enum logic [1:0] {
        SH_IDLE,
        SH_LOW,
        SH_HIGH
    } shift_state_e;

    typedef struct packed {
        logic       go;
        logic [7:0] tx;
    } shift_req_t;

    function automatic logic [7:0] frame_opcode(input phase_e ph);
        case (ph)
            PH_WREN: return OP_WREN;
            PH_PROG: return OP_PROG;
            default: return OP_RDSR;
        endcase
    endfunction

endpackage

// File: rtl/spw_shift.sv
module spw_shift
    import spw_pkg::*;
#(
    parameter int HALF_CYC = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  shift_req_t req,
    input  logic       miso,
    output logic       sck,
    output logic       mosi,
    output logic       done,
    output logic [7:0] rx
);

    localparam int CW = (HALF_CYC < 2) ? 1 : $clog2(HALF_CYC);
    localparam logic [CW-1:0] CNT_END = CW'(HALF_CYC - 1);

    shift_state_e  st;
    logic [CW-1:0] cnt;
    logic [2:0]    bitn;
    logic [7:0]    sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= SH_IDLE;
            cnt  <= '0;
            bitn <= '0;
            sr   <= '0;
            rx   <= '0;
            sck  <= 1'b0;
            mosi <= 1'b0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                SH_IDLE: begin
                    if (req.go) begin
                        sr   <= req.tx;
                        mosi <= req.tx[7];
                        bitn <= 3'd7;
                        cnt  <= '0;
                        st   <= SH_LOW;
                    end
                end
                SH_LOW: begin
                    if (cnt == CNT_END) begin
                        cnt <= '0;
                        sck <= 1'b1;
                        st  <= SH_HIGH;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                SH_HIGH: begin
                    if (cnt == CNT_END) begin
                        cnt <= '0;
                        sck <= 1'b0;
                        rx  <= {rx[6:0], miso};
                        if (bitn == 3'd0) begin
                            done <= 1'b1;
                            st   <= SH_IDLE;
                        end else begin
                            bitn <= bitn - 1'b1;
                            sr   <= {sr[6:0], 1'b0};
                            mosi <= sr[6];
                            st   <= SH_LOW;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: st <= SH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/spw_seq.sv
module spw_seq
    import spw_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int LEN_W      = 16,
    parameter int PAGE_LSB   = 6,
    parameter int CS_GAP     = 4,
    parameter int POLL_LIMIT = 1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              erase,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [LEN_W-1:0]  length,
    input  logic [7:0]        din,
    input  logic              din_valid,
    output logic              din_ready,
    output logic              busy,
    output logic              done,
    output logic              error,
    output logic              cs_n,
    output shift_req_t        sh_req,
    input  logic              sh_done,
    input  logic [7:0]        sh_rx
);

    localparam int GW = (CS_GAP < 2) ? 1 : $clog2(CS_GAP);
    localparam int PW = (POLL_LIMIT < 2) ? 1 : $clog2(POLL_LIMIT);
    localparam logic [GW-1:0] GAP_END  = GW'(CS_GAP - 1);
    localparam logic [PW-1:0] POLL_END = PW'(POLL_LIMIT - 1);

    seq_state_e        state;
    phase_e            phase;
    phase_e            nxt;
    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  rem_q;
    logic              erase_q;
    logic [GW-1:0]     gap_cnt;
    logic [PW-1:0]     polls;
    logic [15:0]       addr16;
    logic              page_end;

    assign addr16    = 16'(addr_q);
    assign page_end  = &addr_q[PAGE_LSB-1:0];
    assign busy      = (state != SEQ_IDLE);
    assign din_ready = (state == SEQ_FEED) && !erase_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= SEQ_IDLE;
            phase   <= PH_RDSR;
            nxt     <= PH_RDSR;
            addr_q  <= '0;
            rem_q   <= '0;
            erase_q <= 1'b0;
            gap_cnt <= '0;
            polls   <= '0;
            cs_n    <= 1'b1;
            sh_req  <= '0;
            done    <= 1'b0;
            error   <= 1'b0;
        end else begin
            done      <= 1'b0;
            error     <= 1'b0;
            sh_req.go <= 1'b0;
            case (state)
                SEQ_IDLE: begin
                    if (start) begin
                        addr_q  <= start_addr;
                        rem_q   <= length;
                        erase_q <= erase;
                        polls   <= '0;
                        gap_cnt <= '0;
                        nxt     <= PH_RDSR;
                        state   <= SEQ_GAP;
                    end
                end
                SEQ_GAP: begin
                    if (gap_cnt == GAP_END) begin
                        cs_n      <= 1'b0;
                        sh_req.go <= 1'b1;
                        sh_req.tx <= frame_opcode(nxt);
                        phase     <= nxt;
                        state     <= SEQ_XFER;
                    end else begin
                        gap_cnt <= gap_cnt + 1'b1;
                    end
                end
                SEQ_FEED: begin
                    if (erase_q || din_valid) begin
                        sh_req.go <= 1'b1;
                        sh_req.tx <= erase_q ? FILL_BYTE : din;
                        phase     <= PH_DATA;
                        state     <= SEQ_XFER;
                    end
                end
                SEQ_XFER: begin
                    if (sh_done) begin
                        case (phase)
                            PH_RDSR: begin
                                sh_req.go <= 1'b1;
                                sh_req.tx <= DUMMY_BYTE;
                                phase     <= PH_DUMMY;
                            end
                            PH_DUMMY: begin
                                cs_n    <= 1'b1;
                                gap_cnt <= '0;
                                if (!sh_rx[WIP_BIT]) begin
                                    polls <= '0;
                                    if (rem_q == '0) begin
                                        done  <= 1'b1;
                                        state <= SEQ_IDLE;
                                    end else begin
                                        nxt   <= PH_WREN;
                                        state <= SEQ_GAP;
                                    end
                                end else if (polls == POLL_END) begin
                                    error <= 1'b1;
                                    state <= SEQ_IDLE;
                                end else begin
                                    polls <= polls + 1'b1;
                                    nxt   <= PH_RDSR;
                                    state <= SEQ_GAP;
                                end
                            end
                            PH_WREN: begin
                                cs_n    <= 1'b1;
                                gap_cnt <= '0;
                                nxt     <= PH_PROG;
                                state   <= SEQ_GAP;
                            end
                            PH_PROG: begin
                                sh_req.go <= 1'b1;
                                sh_req.tx <= addr16[15:8];
                                phase     <= PH_AHI;
                            end
                            PH_AHI: begin
                                sh_req.go <= 1'b1;
                                sh_req.tx <= addr16[7:0];
                                phase     <= PH_ALO;
                            end
                            PH_ALO: begin
                                state <= SEQ_FEED;
                            end
                            PH_DATA: begin
                                addr_q <= addr_q + 1'b1;
                                rem_q  <= rem_q - 1'b1;
                                if (rem_q == LEN_W'(1) || page_end) begin
                                    cs_n    <= 1'b1;
                                    gap_cnt <= '0;
                                    polls   <= '0;
                                    nxt     <= PH_RDSR;
                                    state   <= SEQ_GAP;
                                end else begin
                                    state <= SEQ_FEED;
                                end
                            end
                            default: state <= SEQ_IDLE;
                        endcase
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/spi_page_writer.sv
module spi_page_writer
    import spw_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int LEN_W      = 16,
    parameter int PAGE_LSB   = 6,
    parameter int HALF_CYC   = 2,
    parameter int CS_GAP     = 4,
    parameter int POLL_LIMIT = 1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              erase,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [LEN_W-1:0]  length,
    input  logic [7:0]        din,
    input  logic              din_valid,
    output logic              din_ready,
    output logic              busy,
    output logic              done,
    output logic              error,
    output logic              spi_sck,
    output logic              spi_cs_n,
    output logic              spi_mosi,
    input  logic              spi_miso
);

    shift_req_t sh_req;
    logic       sh_done;
    logic [7:0] sh_rx;

    spw_seq #(
        .ADDR_W    (ADDR_W),
        .LEN_W     (LEN_W),
        .PAGE_LSB  (PAGE_LSB),
        .CS_GAP    (CS_GAP),
        .POLL_LIMIT(POLL_LIMIT)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .erase     (erase),
        .start_addr(start_addr),
        .length    (length),
        .din       (din),
        .din_valid (din_valid),
        .din_ready (din_ready),
        .busy      (busy),
        .done      (done),
        .error     (error),
        .cs_n      (spi_cs_n),
        .sh_req    (sh_req),
        .sh_done   (sh_done),
        .sh_rx     (sh_rx)
    );

    spw_shift #(
        .HALF_CYC(HALF_CYC)
    ) u_shift (
        .clk (clk),
        .rst (rst),
        .req (sh_req),
        .miso(spi_miso),
        .sck (spi_sck),
        .mosi(spi_mosi),
        .done(sh_done),
        .rx  (sh_rx)
    );

endmodule

// File: rtl/spw_checker.sv
module spw_checker #(
    parameter int CS_GAP = 4
) (
    input logic clk,
    input logic rst,
    input logic busy,
    input logic done,
    input logic error,
    input logic din_ready,
    input logic spi_sck,
    input logic spi_cs_n,
    input logic spi_mosi
);

    logic [15:0] hi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q <= '0;
        end else if (!spi_cs_n) begin
            hi_q <= '0;
        end else if (hi_q != 16'hFFFF) begin
            hi_q <= hi_q + 1'b1;
        end
    end

    // R7
    a_r7_cs_gap: assert property (@(posedge clk) disable iff (rst)
        $fell(spi_cs_n) |-> (hi_q >= 16'(CS_GAP)));

    // R6
    a_r6_sck_low_deselected: assert property (@(posedge clk) disable iff (rst)
        spi_cs_n |-> !spi_sck);

    // R6
    a_r6_mosi_hold_high: assert property (@(posedge clk) disable iff (rst)
        (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi));

    // R6
    a_r6_mosi_hold_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(spi_sck) |-> $stable(spi_mosi));

    // R10
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R10
    a_r10_busy_end: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (done || error));

    // R5
    a_r5_outcome_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(done && error));

    // R5
    a_r5_error_pulse: assert property (@(posedge clk) disable iff (rst)
        error |=> !error);

    // R9
    a_r9_ready_in_frame: assert property (@(posedge clk) disable iff (rst)
        din_ready |-> (busy && !spi_cs_n));

endmodule

bind spi_page_writer spw_checker #(
    .CS_GAP(CS_GAP)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .busy     (busy),
    .done     (done),
    .error    (error),
    .din_ready(din_ready),
    .spi_sck  (spi_sck),
    .spi_cs_n (spi_cs_n),
    .spi_mosi (spi_mosi)
);

// File: tb/spi_page_writer_test.sv
module spi_page_writer_test;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 1;
    localparam int GAP        = 3;
    localparam int PLIM       = 20;
    localparam int BUSY_INIT  = 2;
    localparam int BUSY_PAGE  = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        erase = 1'b0;
    logic [15:0] start_addr = '0;
    logic [15:0] length = '0;
    logic [7:0]  din = '0;
    logic        din_valid = 1'b0;
    logic        din_ready;
    logic        busy, done, error;
    logic        spi_sck, spi_cs_n, spi_mosi;
    logic        spi_miso = 1'b0;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    spi_page_writer #(
        .ADDR_W(16), .LEN_W(16), .PAGE_LSB(6),
        .HALF_CYC(HALF), .CS_GAP(GAP), .POLL_LIMIT(PLIM)
    ) uut (
        .clk(clk), .rst(rst), .start(start), .erase(erase),
        .start_addr(start_addr), .length(length),
        .din(din), .din_valid(din_valid), .din_ready(din_ready),
        .busy(busy), .done(done), .error(error),
        .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso)
    );

    function automatic logic [7:0] bg(input int i, input int tag);
        return 8'((i * 5 + tag * 3 + 1) & 255);
    endfunction

    function automatic logic [7:0] dval(input int k);
        return 8'((k * 37 + 11) & 255);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // controls owned by the stimulus process
    int run_tag = 0;
    bit stuck = 1'b0;
    bit gappy = 1'b0;
    int cyc = 0;

    always @(negedge clk) cyc++;

    // data stream driver
    int din_idx = 0;
    bit prev_hs = 1'b0;
    always @(negedge clk) begin
        if (prev_hs) din_idx++;
        din       = dval(din_idx);
        din_valid = gappy ? ((cyc % 3) != 0) : 1'b1;
        prev_hs   = din_valid && din_ready;
    end

    // device model
    logic [7:0] mem [0:511];
    logic [7:0] fb  [0:79];
    int  seen_tag = -1;
    int  busy_left = 0;
    bit  need_poll = 1'b0;
    bit  wel = 1'b0;
    bit  in_frame = 1'b0;
    bit  last_wip = 1'b0;
    bit  p_sck = 1'b0;
    int  nb = 0;
    int  bitc = 0;
    int  hi_cnt = 0;
    int  min_gap = 1000;
    int  frames_run = 0;
    int  stat_frames = 0;
    int  prog_frames = 0;
    int  viol = 0;
    logic [7:0] sh = '0;
    logic [7:0] out_sr = '0;

    always @(negedge clk) begin
        if (run_tag != seen_tag) begin
            seen_tag   = run_tag;
            busy_left  = BUSY_INIT;
            need_poll  = 1'b1;
            wel        = 1'b0;
            min_gap    = 1000;
            frames_run = 0;
            for (int i = 0; i < 512; i++) mem[i] = bg(i, run_tag);
        end
        if (!spi_cs_n) begin
            if (!in_frame) begin
                in_frame = 1'b1;
                nb = 0;
                bitc = 0;
                out_sr = '0;
                if (frames_run > 0 && hi_cnt < min_gap) min_gap = hi_cnt;
            end
            if (spi_sck && !p_sck) begin
                sh = {sh[6:0], spi_mosi};
                bitc++;
                if (bitc == 8) begin
                    bitc = 0;
                    if (nb < 80) fb[nb] = sh;
                    nb++;
                    if (nb == 1 && sh == 8'h05) begin
                        last_wip = stuck || (busy_left > 0);
                        if (busy_left > 0) busy_left--;
                        out_sr = {7'b1011010, last_wip};
                    end
                end
            end
            if (!spi_sck && p_sck) begin
                spi_miso = out_sr[7];
                out_sr   = {out_sr[6:0], 1'b0};
            end
        end else begin
            if (spi_sck) viol++;
            if (in_frame) begin
                in_frame = 1'b0;
                hi_cnt = 1;
                frames_run++;
                if (bitc != 0 || nb == 0) viol++;
                else if (fb[0] == 8'h05) begin
                    stat_frames++;
                    if (nb != 2) viol++;
                    if (!last_wip) need_poll = 1'b0;
                end else if (fb[0] == 8'h06) begin
                    if (nb != 1 || need_poll) viol++;
                    wel = 1'b1;
                end else if (fb[0] == 8'h02) begin
                    int a;
                    int nd;
                    if (!wel || nb < 4 || need_poll) viol++;
                    a  = {fb[1], fb[2]};
                    nd = nb - 3;
                    if ((a % 64) + nd > 64) viol++;
                    for (int k = 0; k < nd && k < 77; k++) mem[(a + k) % 512] = fb[3 + k];
                    prog_frames++;
                    wel = 1'b0;
                    need_poll = 1'b1;
                    busy_left = BUSY_PAGE;
                end else viol++;
            end else begin
                hi_cnt++;
            end
        end
        p_sck = spi_sck;
    end

    task automatic run_job(input int a, input int n, input bit er, input bit gp,
                           input bit stk, input bit poke);
        int base, s0, p0, v0, dn, ec, pages, mism, consumed, t;
        bit fin;
        logic [7:0] expv;
        stuck = stk;
        gappy = gp;
        run_tag++;
        repeat (3) @(negedge clk);
        base = din_idx; s0 = stat_frames; p0 = prog_frames; v0 = viol;
        start = 1'b1; start_addr = 16'(a); length = 16'(n); erase = er;
        @(negedge clk);
        start = 1'b0;
        dn = 0; ec = 0; fin = 1'b0; t = 0;
        while (!fin && t < 30000) begin
            @(negedge clk);
            t++;
            if (done) dn++;
            if (error) ec++;
            if (dn + ec > 0) fin = 1'b1;
            if (poke && t == 150) begin
                start = 1'b1; start_addr = 16'd300; length = 16'd5; erase = 1'b1;
            end else begin
                start = 1'b0;
            end
        end
        start = 1'b0;
        repeat (4) begin
            @(negedge clk);
            if (done) dn++;
            if (error) ec++;
        end
        consumed = din_idx - base;
        pages = (n == 0) ? 0 : ((a % 64) + n + 63) / 64;
        if (stk) begin
            chk(ec == 1 && dn == 0, "R5 error pulse", ec * 10 + dn, 10);
            chk(stat_frames - s0 == PLIM, "R5 poll count", stat_frames - s0, PLIM);
            chk(prog_frames - p0 == 0, "R5 no program", prog_frames - p0, 0);
        end else begin
            chk(dn == 1 && ec == 0, "R10 done pulse", dn * 10 + ec, 10);
            chk(prog_frames - p0 == pages, "R3 page frames", prog_frames - p0, pages);
            chk(stat_frames - s0 == (BUSY_INIT + 1) + pages * (BUSY_PAGE + 1),
                "R4 R1 status polls", stat_frames - s0,
                (BUSY_INIT + 1) + pages * (BUSY_PAGE + 1));
            mism = 0;
            for (int i = 0; i < 512; i++) begin
                expv = bg(i, run_tag);
                if (i >= a && i < a + n) expv = er ? 8'hFF : dval(base + i - a);
                if (mem[i] !== expv) mism++;
            end
            chk(mism == 0, poke ? "R11 start ignored (memory)" : "R2 memory image", mism, 0);
            chk(consumed == (er ? 0 : n), er ? "R8 erase takes no data" : "R9 bytes taken",
                consumed, er ? 0 : n);
        end
        chk(viol - v0 == 0, "R6 R1 R2 frame rules", viol - v0, 0);
        if (frames_run > 1) chk(min_gap >= GAP, "R7 deselect time", min_gap, GAP);
        chk(!busy && spi_cs_n, "R10 idle after job", busy, 0);
    endtask

    initial begin
        int addrs [5];
        int lens  [7];
        addrs = '{0, 5, 62, 63, 74};
        lens  = '{0, 1, 2, 63, 64, 65, 130};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(spi_cs_n == 1'b1, "R12 cs_n", spi_cs_n, 1);
        chk(spi_sck == 1'b0, "R12 sck", spi_sck, 0);
        chk(busy == 1'b0 && din_ready == 1'b0, "R12 busy/ready", busy + din_ready, 0);
        chk(done == 1'b0 && error == 1'b0, "R12 done/error", done + error, 0);
        for (int ai = 0; ai < 5; ai++)
            for (int li = 0; li < 7; li++)
                run_job(addrs[ai], lens[li], 1'b0, ((ai + li) % 2) == 1, 1'b0, 1'b0);
        run_job(3, 1, 1'b1, 1'b0, 1'b0, 1'b0);
        run_job(64, 70, 1'b1, 1'b1, 1'b0, 1'b0);
        run_job(100, 0, 1'b1, 1'b0, 1'b0, 1'b0);
        run_job(10, 20, 1'b0, 1'b0, 1'b0, 1'b1);
        run_job(0, 10, 1'b0, 1'b0, 1'b1, 1'b0);
        run_job(40, 30, 1'b0, 1'b0, 1'b0, 1'b0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule